// File: doc/BRIEF.md
# Dual Latched Interval Timer Pair

This block holds two 16-bit down-counters. Each one has its own reload latch and is reached over a byte-wide register port. Software sets a latch one byte at a time. A write to a counter's high-byte address then moves the whole latch into the counter and arms the timer. After that, the counter steps down by one on every cycle in which the `tick` enable input is high.

When a counter steps from zero to 0xFFFF, its interrupt flag is raised. The flag stays high until software clears it through one of the register side effects.

- **Timer 1** can run one-shot or free-running. In free-running mode it reloads itself from its latch after the wrap, so one period is the latch value plus two ticks.
- **Timer 2** is one-shot only.

An auxiliary control byte selects the timer 1 mode. The two flag outputs are meant to feed a separate interrupt controller.

Top module: `dual_interval_timer`

## Requirements
- R1: After a synchronous reset:
  - both latches and both counters read 0xFFFF;
  - both flags are low;
  - the auxiliary control byte (address 6) reads 0x00.
- R2: A counter changes only on a cycle with `tick` high, or on a load. On a tick it steps down by one and goes from 0x0000 to 0xFFFF. In free-running mode timer 1 goes from 0xFFFF (reached by that wrap) back to its latch value, so one period is latch + 2 ticks.
- R3: Writes to the low-byte addresses replace only the low byte of that timer's latch and leave the running counter as it is. These addresses are 0 (timer 1 counter low), 2 (timer 1 latch low) and 4 (timer 2 low).
- R4: A write to a counter high-byte address (1 for timer 1, 5 for timer 2) does four things:
  - stores the byte as the latch high byte;
  - loads the counter with the full 16-bit latch;
  - clears that timer's flag;
  - arms the one-shot.
  If a tick arrives in the same cycle, it has no effect on that timer.
- R5: A write to address 3 replaces the timer 1 latch high byte and clears the timer 1 flag. It does not reload the counter.
- R6: A read returns its byte on `rd_data` on the cycle after `rd_en`, with the value the block held before that clock edge.
  - A read of a counter low byte (address 0 or 4) clears that timer's flag.
  - A read of a counter high byte (address 1 or 5) leaves the flag unchanged.
- R7: Reads of address 2 and address 3 return the timer 1 latch low and high bytes. They have no side effect on either flag or counter.
- R8: Address 6 holds the auxiliary control byte, which reads back as written. Bit 6 = 1 selects free-running mode for timer 1; bit 6 = 0 selects one-shot.
- R9: In free-running mode, timer 1 raises its flag on every tick that moves its counter from 0x0000 to 0xFFFF.
- R10: In one-shot mode, a timer raises its flag only on the first zero-to-0xFFFF wrap after a high-byte load. The counter keeps counting down and wrapping after that, but the flag is not raised again.
- R11: If a flag-setting wrap and a flag clear (a read of the low byte, or a write to address 3) fall in the same cycle, the flag ends up set.
- R12: Addresses 7 to 15 read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable; each high cycle is one timer tick |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte, valid the cycle after `rd_en` |
| t1_flag | output | 1 | Timer 1 interrupt flag |
| t2_flag | output | 1 | Timer 2 interrupt flag |

## Verification
- **Lost arm or wrong reload value.** This only shows up when a wrap happens, so the bench counts the ticks up to each expected wrap. It then reads the count and the flag on the cycle right after.
- **Missing free-running reload.** A wrong under-flow marker makes timer 1 drift by one tick per period, so the bench checks the count one tick after the wrap and again one full period later.
- **One-shot re-firing.** This appears only after a complete 65536-tick lap, so timer 2 is run through an entire lap.
- **Same-cycle priorities.** These are checked by driving a tick together with a read or a write in a single cycle.

// File: rtl/dit_pkg.sv
package dit_pkg;
  // Register offsets; the read/clear side effects depend on these.
  localparam int OFS_T1_CNT_LO = 0;
  localparam int OFS_T1_CNT_HI = 1;
  localparam int OFS_T1_LAT_LO = 2;
  localparam int OFS_T1_LAT_HI = 3;
  localparam int OFS_T2_CNT_LO = 4;
  localparam int OFS_T2_CNT_HI = 5;
  localparam int OFS_AUX       = 6;

  // Auxiliary control bit that selects free-running timer 1.
  localparam int AUX_FREE_BIT  = 6;

  localparam int NUM_TMR       = 2;

  typedef struct packed {
    logic lat_lo_wr;  // replace latch low byte
    logic cnt_hi_wr;  // latch high byte + load counter + arm
    logic lat_hi_wr;  // latch high byte only
    logic flag_clr;   // clear request for the flag
  } tmr_ctl_t;
endpackage

// File: rtl/dit_decode.sv
module dit_decode
  import dit_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output tmr_ctl_t [NUM_TMR-1:0] ctl,
  output logic              aux_wr
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    ctl[0].lat_lo_wr = wr_en && (hit(addr, OFS_T1_CNT_LO) || hit(addr, OFS_T1_LAT_LO));
    ctl[0].cnt_hi_wr = wr_en && hit(addr, OFS_T1_CNT_HI);
    ctl[0].lat_hi_wr = wr_en && hit(addr, OFS_T1_LAT_HI);
    ctl[0].flag_clr  = (rd_en && hit(addr, OFS_T1_CNT_LO)) ||
                       (wr_en && hit(addr, OFS_T1_LAT_HI));

    ctl[1].lat_lo_wr = wr_en && hit(addr, OFS_T2_CNT_LO);
    ctl[1].cnt_hi_wr = wr_en && hit(addr, OFS_T2_CNT_HI);
    ctl[1].lat_hi_wr = 1'b0;
    ctl[1].flag_clr  = rd_en && hit(addr, OFS_T2_CNT_LO);

    aux_wr           = wr_en && hit(addr, OFS_AUX);
  end
endmodule

// File: rtl/dit_counter.sv
module dit_counter
  import dit_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 2 * DATA_W,
  parameter bit RELOAD_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              free_run,
  input  tmr_ctl_t          ctl,
  input  logic [DATA_W-1:0] wr_byte,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  latch,
  output logic              flag
);
  logic armed;
  logic under;   // counter reached all-ones by a wrap on the previous tick
  logic reload_now;
  logic fire;

  generate
    if (RELOAD_EN) begin : g_reload
      assign reload_now = free_run && under;
    end else begin : g_noreload
      assign reload_now = 1'b0;
    end
  endgenerate

  assign fire = tick && !ctl.cnt_hi_wr && (count == '0) &&
                ((RELOAD_EN && free_run) || armed);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= '1;
      count <= '1;
      flag  <= 1'b0;
      armed <= 1'b0;
      under <= 1'b0;
    end else begin
      if (ctl.lat_lo_wr)
        latch[DATA_W-1:0] <= wr_byte;
      if (ctl.cnt_hi_wr || ctl.lat_hi_wr)
        latch[CNT_W-1:DATA_W] <= wr_byte;

      if (ctl.cnt_hi_wr) begin
        count <= {wr_byte, latch[DATA_W-1:0]};
        armed <= 1'b1;
        under <= 1'b0;
        flag  <= 1'b0;
      end else begin
        if (tick) begin
          under <= (count == '0);
          if (reload_now)
            count <= latch;
          else
            count <= count - 1'b1;
        end
        if (fire) begin
          flag  <= 1'b1;
          armed <= 1'b0;
        end else if (ctl.flag_clr) begin
          flag  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dit_readback.sv
module dit_readback
  import dit_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  t1_count,
  input  logic [CNT_W-1:0]  t1_latch,
  input  logic [CNT_W-1:0]  t2_count,
  input  logic [DATA_W-1:0] aux,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mux;

  always_comb begin
    mux = '0;
    if      (addr == ADDR_W'(OFS_T1_CNT_LO)) mux = t1_count[DATA_W-1:0];
    else if (addr == ADDR_W'(OFS_T1_CNT_HI)) mux = t1_count[CNT_W-1:DATA_W];
    else if (addr == ADDR_W'(OFS_T1_LAT_LO)) mux = t1_latch[DATA_W-1:0];
    else if (addr == ADDR_W'(OFS_T1_LAT_HI)) mux = t1_latch[CNT_W-1:DATA_W];
    else if (addr == ADDR_W'(OFS_T2_CNT_LO)) mux = t2_count[DATA_W-1:0];
    else if (addr == ADDR_W'(OFS_T2_CNT_HI)) mux = t2_count[CNT_W-1:DATA_W];
    else if (addr == ADDR_W'(OFS_AUX))       mux = aux;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= mux;
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              t1_flag,
  output logic              t2_flag
);
  localparam int CNT_W = 2 * DATA_W;

  tmr_ctl_t [NUM_TMR-1:0] ctl;
  logic                   aux_wr;
  logic [DATA_W-1:0]      aux;
  logic                   free_run;
  logic [CNT_W-1:0]       cnt [NUM_TMR];
  logic [CNT_W-1:0]       lat [NUM_TMR];
  logic [NUM_TMR-1:0]     flg;

  logic [CNT_W-1:0] t1_count, t1_latch, t2_count, t2_latch;

  dit_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .ctl   (ctl),
    .aux_wr(aux_wr)
  );

  always_ff @(posedge clk) begin
    if (rst)
      aux <= '0;
    else if (aux_wr)
      aux <= wr_data;
  end

  assign free_run = aux[AUX_FREE_BIT];

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    dit_counter #(
      .DATA_W   (DATA_W),
      .CNT_W    (CNT_W),
      .RELOAD_EN(g == 0)
    ) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .free_run((g == 0) ? free_run : 1'b0),
      .ctl     (ctl[g]),
      .wr_byte (wr_data),
      .count   (cnt[g]),
      .latch   (lat[g]),
      .flag    (flg[g])
    );
  end

  assign t1_count = cnt[0];
  assign t1_latch = lat[0];
  assign t2_count = cnt[1];
  assign t2_latch = lat[1];
  assign t1_flag  = flg[0];
  assign t2_flag  = flg[1];

  dit_readback #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_rb (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .addr    (addr),
    .t1_count(t1_count),
    .t1_latch(t1_latch),
    .t2_count(t2_count),
    .aux     (aux),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/dual_interval_timer_chk.sv
module dual_interval_timer_chk
  import dit_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              t1_flag,
  input logic              t2_flag,
  input logic              free_run,
  input logic [CNT_W-1:0]  t1_count,
  input logic [CNT_W-1:0]  t1_latch,
  input logic [CNT_W-1:0]  t2_count,
  input logic [CNT_W-1:0]  t2_latch
);
  logic t1_load, t2_load, t1_wrap, t2_wrap;
  assign t1_load = wr_en && addr == ADDR_W'(OFS_T1_CNT_HI);
  assign t2_load = wr_en && addr == ADDR_W'(OFS_T2_CNT_HI);
  assign t1_wrap = tick && t1_count == '0;
  assign t2_wrap = tick && t2_count == '0;

  assert_t1_load_R4: assert property (@(posedge clk) disable iff (rst)
    t1_load |=> t1_count == {$past(wr_data), $past(t1_latch[DATA_W-1:0])} && !t1_flag);

  assert_t2_load_R4: assert property (@(posedge clk) disable iff (rst)
    t2_load |=> t2_count == {$past(wr_data), $past(t2_latch[DATA_W-1:0])} && !t2_flag);

  assert_lathi_clear_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en && addr == ADDR_W'(OFS_T1_LAT_HI) && !t1_wrap
    |=> !t1_flag && t1_latch[CNT_W-1:DATA_W] == $past(wr_data));

  assert_t1_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !tick && !t1_load |=> $stable(t1_count));

  assert_t2_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !tick && !t2_load |=> $stable(t2_count));

  assert_t1_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    t1_wrap && !t1_load |=> t1_count == '1);

  assert_freerun_fire_R9: assert property (@(posedge clk) disable iff (rst)
    t1_wrap && free_run && !t1_load |=> t1_flag);

  assert_t1_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(t1_flag) |-> $past(tick) && $past(t1_count) == '0);

  assert_t2_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(t2_flag) |-> $past(tick) && $past(t2_count) == '0);

  assert_t1_rdclr_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == ADDR_W'(OFS_T1_CNT_LO) && !t1_wrap && !wr_en |=> !t1_flag);

  assert_t2_rdclr_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == ADDR_W'(OFS_T2_CNT_LO) && !t2_wrap && !wr_en |=> !t2_flag);
endmodule

bind dual_interval_timer dual_interval_timer_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wr_data (wr_data),
  .t1_flag (t1_flag),
  .t2_flag (t2_flag),
  .free_run(free_run),
  .t1_count(t1_count),
  .t1_latch(t1_latch),
  .t2_count(t2_count),
  .t2_latch(t2_latch)
);

// File: tb/tb_dual_interval_timer.sv
`timescale 1ns/1ps
module tb_dual_interval_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       t1_flag, t2_flag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_interval_timer dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .t1_flag(t1_flag), .t2_flag(t2_flag)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(4'(a), v); chk($sformatf("R1 reset byte addr %0d", a), v, 8'hFF);
    end
    rd(4'd6, v); chk("R1 reset aux", v, 8'h00);
    chk("R1 reset t1_flag", t1_flag, 0);
    chk("R1 reset t2_flag", t2_flag, 0);
  endtask

  task automatic t_t1_oneshot;
    logic [7:0] v;
    wr(4'd0, 8'h03); wr(4'd1, 8'h00);
    rd(4'd0, v); chk("R4 t1 load low", v, 8'h03);
    rd(4'd1, v); chk("R6 t1 high byte", v, 8'h00);
    chk("R4 t1 flag after load", t1_flag, 0);
    ticks(3);
    rd(4'd0, v); chk("R2 t1 count at zero", v, 8'h00);
    chk("R10 no flag before wrap", t1_flag, 0);
    ticks(1);
    chk("R10 t1 one-shot fires", t1_flag, 1);
    rd(4'd1, v); chk("R6 high read value", v, 8'hFF);
    chk("R6 high read keeps flag", t1_flag, 1);
    rd(4'd0, v); chk("R6 low read value", v, 8'hFF);
    chk("R6 low read clears flag", t1_flag, 0);
    ticks(1);
    rd(4'd0, v); chk("R10 one-shot no reload", v, 8'hFE);
  endtask

  task automatic t_latch_access;
    logic [7:0] v;
    wr(4'd2, 8'h99);
    rd(4'd0, v); chk("R3 latch-low write keeps count", v, 8'hFE);
    rd(4'd2, v); chk("R7 latch low read", v, 8'h99);
    wr(4'd0, 8'h77);
    rd(4'd2, v); chk("R3 count-low write hits latch", v, 8'h77);
    rd(4'd0, v); chk("R3 count-low write keeps count", v, 8'hFE);
    wr(4'd0, 8'h01); wr(4'd1, 8'h00);
    ticks(2);
    chk("R10 fire setup", t1_flag, 1);
    rd(4'd2, v); chk("R7 latch low value", v, 8'h01);
    rd(4'd3, v); chk("R7 latch high value", v, 8'h00);
    chk("R7 latch reads keep flag", t1_flag, 1);
    wr(4'd3, 8'h12);
    chk("R5 latch-high write clears flag", t1_flag, 0);
    rd(4'd1, v); chk("R5 no reload high", v, 8'hFF);
    rd(4'd0, v); chk("R5 no reload low", v, 8'hFF);
    rd(4'd3, v); chk("R5 latch high stored", v, 8'h12);
  endtask

  task automatic t_freerun;
    logic [7:0] v;
    wr(4'd6, 8'h40);
    rd(4'd6, v); chk("R8 aux readback", v, 8'h40);
    wr(4'd0, 8'h04); wr(4'd1, 8'h00);
    ticks(4);
    rd(4'd0, v); chk("R2 free count zero", v, 8'h00);
    chk("R9 no early flag", t1_flag, 0);
    ticks(1);
    chk("R9 first free fire", t1_flag, 1);
    rd(4'd0, v); chk("R2 wrap to FFFF", v, 8'hFF);
    ticks(1);
    rd(4'd0, v); chk("R2 reload from latch", v, 8'h04);
    chk("R9 flag cleared", t1_flag, 0);
    ticks(4);
    chk("R9 no flag mid period", t1_flag, 0);
    ticks(1);
    chk("R9 second free fire after latch+2", t1_flag, 1);
    rd(4'd0, v); chk("R2 second wrap", v, 8'hFF);
    wr(4'd6, 8'h00);
  endtask

  task automatic t_t2_oneshot;
    logic [7:0] v;
    wr(4'd4, 8'h02); wr(4'd5, 8'h00);
    rd(4'd4, v); chk("R4 t2 load", v, 8'h02);
    ticks(3);
    chk("R10 t2 fires", t2_flag, 1);
    rd(4'd5, v); chk("R6 t2 high read", v, 8'hFF);
    chk("R6 t2 high read keeps flag", t2_flag, 1);
    rd(4'd4, v); chk("R6 t2 low read", v, 8'hFF);
    chk("R6 t2 low read clears", t2_flag, 0);
    ticks(65536);
    rd(4'd4, v); chk("R10 t2 full lap count", v, 8'hFF);
    chk("R10 t2 no second fire", t2_flag, 0);
    wr(4'd4, 8'h33);
    rd(4'd4, v); chk("R3 t2 low write keeps count", v, 8'hFF);
  endtask

  task automatic t_same_cycle;
    logic [7:0] v;
    wr(4'd4, 8'h01); wr(4'd5, 8'h00);
    ticks(1);
    @(negedge clk); tick = 1'b1; rd_en = 1'b1; addr = 4'd4;
    @(negedge clk); tick = 1'b0; rd_en = 1'b0; v = rd_data;
    chk("R11 read value at wrap", v, 8'h00);
    chk("R11 set wins over read clear", t2_flag, 1);
    wr(4'd4, 8'h05);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 4'd5; wr_data = 8'h00;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd(4'd4, v); chk("R4 load beats tick", v, 8'h05);
    chk("R4 load clears t2 flag", t2_flag, 0);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    wr(4'd9, 8'h55);
    rd(4'd9, v); chk("R12 unmapped reads zero", v, 8'h00);
    rd(4'd6, v); chk("R12 aux untouched", v, 8'h00);
    rd(4'd2, v); chk("R12 latch untouched", v, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_t1_oneshot();
    t_latch_access();
    t_freerun();
    t_t2_oneshot();
    t_same_cycle();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule